// File: doc/BRIEF.md
# DMA Bus Request Qualifier

This block sits between a DMA engine and the arbiter of a shared on-chip bus. It decides, cycle by cycle, whether the engine's raw bus request may go out to the arbiter. A request is withheld while the bus's current interrupt service level is above a programmable mask. It is also withheld while a debug freeze is in force and the configuration tells the channel to honour it. The block also drives the arbitration priority that goes with the request.

A 16-bit configuration word holds a freeze mode, the service mask, the arbitration priority and an enable for the bus-error interrupt. A bus error seen while the engine is granted the bus sets a sticky status flag. The interrupt output is that flag qualified by the enable. Software clears the flag by writing a one to it.

Top module: `dma_req_qualifier`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `bus_req`, `err_status` and `err_irq` are 0, `cfg_rdata` is 0 and `arb_id` is 0.
- R2: A configuration write stores the freeze mode from bits 14:13, the service mask from bits 10:8, the arbitration priority from bits 6:4 and the error-interrupt enable from bit 1. `cfg_rdata` returns these fields at the same positions, and every other bit reads 0 whatever was written.
- R3: With no gating condition active, `bus_req` equals `raw_req` as it was at the previous clock edge.
- R4: If `irq_level` is strictly greater than the stored mask at a clock edge, `bus_req` is 0 after that edge. A level equal to or below the mask does not block the request.
- R5: With freeze mode 2'b10, `freeze_in` high and `xfer_busy` low at a clock edge, `bus_req` is 0 after that edge. It stays 0 for as long as `freeze_in` stays high, and it follows `raw_req` again one edge after `freeze_in` falls.
- R6: With freeze mode 2'b10, if `freeze_in` rises while `xfer_busy` is high, `bus_req` stays high until the edge at which `xfer_ack` is high. It is 0 after that edge.
- R7: With freeze mode 2'b00, 2'b01 or 2'b11, `freeze_in` has no effect on `bus_req`.
- R8: `arb_id` always equals the stored priority field (0 lowest, 7 highest).
- R9: `bus_err` high together with `bus_grant` at a clock edge sets `err_status` after that edge. `bus_err` without `bus_grant` leaves it unchanged.
- R10: `err_irq` is high exactly when `err_status` and the stored enable are both 1. With the enable at 0 a bus error still sets `err_status`. Setting the enable while `err_status` is 1 raises `err_irq`.
- R11: A status write with `sts_wdata` = 1 clears `err_status`. A status write with `sts_wdata` = 0 has no effect. A bus error at the same edge as a clearing write wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data, 1 clears the flag |
| raw_req | input | 1 | Bus request from the DMA engine |
| freeze_in | input | 1 | Debug freeze |
| irq_level | input | 3 | Interrupt service level currently on the bus |
| xfer_busy | input | 1 | A bus transfer of this channel is in progress |
| xfer_ack | input | 1 | Acknowledge ending the current transfer |
| bus_grant | input | 1 | This channel owns the bus |
| bus_err | input | 1 | Bus error on the current cycle |
| bus_req | output | 1 | Qualified, registered bus request |
| arb_id | output | 3 | Arbitration priority sent with the request |
| err_status | output | 1 | Sticky bus-error flag |
| err_irq | output | 1 | Bus-error interrupt |

## Verification
Every state-holding result (`bus_req`, `err_status`, `cfg_rdata`) is due one edge after the inputs that cause it. `arb_id` and `err_irq` follow the stored registers in the same cycle. The bench drives each vector half a period before an edge and queues the values expected after that edge. The monitor compares them a quarter period after the edge. A configuration write still gates `bus_req` with the old configuration at the write edge, and the expected values take this into account.

// File: rtl/dbrq_pkg.sv
package dbrq_pkg;

    parameter int CFG_W = 16;
    parameter int LVL_W = 3;
    parameter int ID_W  = 3;

    localparam int MODE_LSB = 13;
    localparam int MASK_LSB = 8;
    localparam int ID_LSB   = 4;
    localparam int IE_BIT   = 1;

    typedef enum logic [1:0] {
        FRZ_IGNORE = 2'b00,
        FRZ_RSV_A  = 2'b01,
        FRZ_STOP   = 2'b10,
        FRZ_RSV_B  = 2'b11
    } frz_mode_e;

    typedef struct packed {
        frz_mode_e        mode;
        logic [LVL_W-1:0] mask;
        logic [ID_W-1:0]  prio;
        logic             err_ie;
    } cfg_t;

    function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.mode   = frz_mode_e'(w[MODE_LSB +: 2]);
        c.mask   = w[MASK_LSB +: LVL_W];
        c.prio   = w[ID_LSB +: ID_W];
        c.err_ie = w[IE_BIT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_encode(input cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[MODE_LSB +: 2]     = c.mode;
        w[MASK_LSB +: LVL_W] = c.mask;
        w[ID_LSB +: ID_W]    = c.prio;
        w[IE_BIT]            = c.err_ie;
        return w;
    endfunction

    localparam logic [CFG_W-1:0] CFG_LIVE_BITS = cfg_encode('{FRZ_RSV_B, '1, '1, 1'b1});

endpackage

// File: rtl/dbrq_cfg_reg.sv
module dbrq_cfg_reg
    import dbrq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{FRZ_IGNORE, '0, '0, 1'b0};
        end else if (wr) begin
            cfg_q <= cfg_decode(wdata);
        end
    end

    logic unused_rsv;
    assign unused_rsv = ^(wdata & ~CFG_LIVE_BITS);

    assign cfg   = cfg_q;
    assign rdata = cfg_encode(cfg_q);
endmodule

// File: rtl/dbrq_req_gate.sv
module dbrq_req_gate
    import dbrq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frz_mode_e        mode,
    input  logic [LVL_W-1:0] mask,
    input  logic             raw_req,
    input  logic             freeze_in,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             xfer_busy,
    input  logic             xfer_ack,
    output logic             bus_req
);
    logic frozen_q;
    logic frozen_d;
    logic lvl_block;
    logic req_q;

    // Freeze takes hold at a transfer boundary and persists while freeze_in stays high
    assign frozen_d  = (mode == FRZ_STOP) && freeze_in &&
                       (frozen_q || !xfer_busy || xfer_ack);
    assign lvl_block = irq_level > mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            frozen_q <= frozen_d;
            req_q    <= raw_req && !lvl_block && !frozen_d;
        end
    end

    assign bus_req = req_q;
endmodule

// File: rtl/dbrq_err_status.sv
module dbrq_err_status (
    input  logic clk,
    input  logic rst,
    input  logic bus_err,
    input  logic bus_grant,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic err_ie,
    output logic status,
    output logic irq
);
    logic sts_q;
    logic set_now;
    logic clr_now;

    assign set_now = bus_err && bus_grant;
    assign clr_now = clr_wr && clr_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= 1'b0;
        end else if (set_now) begin
            sts_q <= 1'b1;
        end else if (clr_now) begin
            sts_q <= 1'b0;
        end
    end

    assign status = sts_q;
    assign irq    = sts_q && err_ie;
endmodule

// File: rtl/dma_req_qualifier.sv
module dma_req_qualifier
    import dbrq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             sts_wr,
    input  logic             sts_wdata,
    input  logic             raw_req,
    input  logic             freeze_in,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             xfer_busy,
    input  logic             xfer_ack,
    input  logic             bus_grant,
    input  logic             bus_err,
    output logic             bus_req,
    output logic [ID_W-1:0]  arb_id,
    output logic             err_status,
    output logic             err_irq
);
    cfg_t cfg;

    dbrq_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    dbrq_req_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg.mode),
        .mask      (cfg.mask),
        .raw_req   (raw_req),
        .freeze_in (freeze_in),
        .irq_level (irq_level),
        .xfer_busy (xfer_busy),
        .xfer_ack  (xfer_ack),
        .bus_req   (bus_req)
    );

    dbrq_err_status u_err (
        .clk       (clk),
        .rst       (rst),
        .bus_err   (bus_err),
        .bus_grant (bus_grant),
        .clr_wr    (sts_wr),
        .clr_bit   (sts_wdata),
        .err_ie    (cfg.err_ie),
        .status    (err_status),
        .irq       (err_irq)
    );

    assign arb_id = cfg.prio;
endmodule

// File: rtl/dbrq_checker.sv
module dbrq_checker
    import dbrq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             sts_wr,
    input logic             sts_wdata,
    input logic             raw_req,
    input logic             freeze_in,
    input logic [LVL_W-1:0] irq_level,
    input logic             xfer_busy,
    input logic             xfer_ack,
    input logic             bus_grant,
    input logic             bus_err,
    input logic             bus_req,
    input logic [ID_W-1:0]  arb_id,
    input logic             err_status,
    input logic             err_irq
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!bus_req && !err_status && cfg_rdata == '0));

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~CFG_LIVE_BITS) == '0);

    assert_no_raw_no_req_R3: assert property (@(posedge clk) disable iff (rst)
        !raw_req |=> !bus_req);

    assert_open_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (raw_req && !freeze_in && irq_level <= cfg_rdata[MASK_LSB +: LVL_W]) |=> bus_req);

    assert_level_block_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_level > cfg_rdata[MASK_LSB +: LVL_W]) |=> !bus_req);

    assert_idle_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[MODE_LSB +: 2] == 2'b10 && freeze_in && !xfer_busy) |=> !bus_req);

    assert_ack_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[MODE_LSB +: 2] == 2'b10 && freeze_in && xfer_ack) |=> !bus_req);

    assert_err_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_err && bus_grant) |=> err_status);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> err_status);

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_wdata && !(bus_err && bus_grant)) |=> !err_status);

    logic unused_chk;
    assign unused_chk = ^{cfg_wr, cfg_wdata, arb_id};
endmodule

bind dma_req_qualifier dbrq_checker chk_i (.*);

// File: tb/dma_req_qualifier_tb_top.sv
module dma_req_qualifier_tb_top;
    import dbrq_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic             sts_wr = 1'b0;
    logic             sts_wdata = 1'b0;
    logic             raw_req = 1'b0;
    logic             freeze_in = 1'b0;
    logic [LVL_W-1:0] irq_level = '0;
    logic             xfer_busy = 1'b0;
    logic             xfer_ack = 1'b0;
    logic             bus_grant = 1'b0;
    logic             bus_err = 1'b0;
    logic             bus_req;
    logic [ID_W-1:0]  arb_id;
    logic             err_status;
    logic             err_irq;

    always #10 clk = ~clk;

    dma_req_qualifier dut_i (.*);

    typedef struct {
        logic             req;
        logic             sts;
        logic             irq;
        logic [CFG_W-1:0] rdata;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    logic [CFG_W-1:0] cur_cfg = '0;
    bit   done = 1'b0;

    // Driver: inputs set at the falling edge, expectation for the coming rising edge queued
    task automatic step(input logic e_req, input logic e_sts, input logic e_irq, input string tag);
        exp_t e;
        e.req = e_req; e.sts = e_sts; e.irq = e_irq; e.rdata = cur_cfg; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        sts_wr = 1'b0;
        sts_wdata = 1'b0;
    endtask

    task automatic wcfg(input logic [CFG_W-1:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        cur_cfg = v & 16'h6772;
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            n_vec++;
            bad = 1'b0;
            if (bus_req !== e.req) begin
                $display("FAIL %s bus_req actual %0b expected %0b", e.tag, bus_req, e.req); bad = 1'b1;
            end
            if (err_status !== e.sts) begin
                $display("FAIL %s err_status actual %0b expected %0b", e.tag, err_status, e.sts); bad = 1'b1;
            end
            if (err_irq !== e.irq) begin
                $display("FAIL %s err_irq actual %0b expected %0b", e.tag, err_irq, e.irq); bad = 1'b1;
            end
            if (cfg_rdata !== e.rdata) begin
                $display("FAIL %s cfg_rdata actual %h expected %h", e.tag, cfg_rdata, e.rdata); bad = 1'b1;
            end
            if (arb_id !== e.rdata[6:4]) begin
                $display("FAIL %s/R8 arb_id actual %0d expected %0d", e.tag, arb_id, e.rdata[6:4]); bad = 1'b1;
            end
            if (bad) n_fail++;
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1; raw_req = 1'b1; bus_grant = 1'b1; bus_err = 1'b1;
        step(0, 0, 0, "R1 reset a");
        step(0, 0, 0, "R1 reset b");
        rst = 1'b0; bus_grant = 1'b0; bus_err = 1'b0;
        step(1, 0, 0, "R3 pass");
        raw_req = 1'b0;
        step(0, 0, 0, "R3 drop");
        raw_req = 1'b1; wcfg(16'hFFFF);
        step(1, 0, 0, "R2 reserved read zero");
        irq_level = 3'd7;
        step(1, 0, 0, "R4 level equal mask");
        wcfg(16'h0350); irq_level = 3'd3;
        step(1, 0, 0, "R2 R8 new fields");
        irq_level = 3'd4;
        step(0, 0, 0, "R4 level above mask");
        irq_level = 3'd3;
        step(1, 0, 0, "R4 level back to mask");
        wcfg(16'h4350);
        step(1, 0, 0, "R5 mode written");
        freeze_in = 1'b1;
        step(0, 0, 0, "R5 idle freeze");
        step(0, 0, 0, "R5 freeze held");
        freeze_in = 1'b0;
        step(1, 0, 0, "R5 freeze released");
        xfer_busy = 1'b1; freeze_in = 1'b1;
        step(1, 0, 0, "R6 busy no ack");
        step(1, 0, 0, "R6 busy still");
        xfer_ack = 1'b1;
        step(0, 0, 0, "R6 ack edge");
        xfer_ack = 1'b0; xfer_busy = 1'b0;
        step(0, 0, 0, "R6 after ack");
        freeze_in = 1'b0;
        step(1, 0, 0, "R6 release");
        wcfg(16'h2350);
        step(1, 0, 0, "R7 mode 01 written");
        freeze_in = 1'b1;
        step(1, 0, 0, "R7 mode 01 ignores freeze");
        wcfg(16'h6350);
        step(1, 0, 0, "R7 mode 11 written");
        step(1, 0, 0, "R7 mode 11 ignores freeze");
        freeze_in = 1'b0; wcfg(16'h0350);
        step(1, 0, 0, "R7 mode 00");
        freeze_in = 1'b1;
        step(1, 0, 0, "R7 mode 00 ignores freeze");
        freeze_in = 1'b0; raw_req = 1'b0;
        bus_grant = 1'b1; bus_err = 1'b1;
        step(0, 1, 0, "R10 masked error sets flag");
        bus_err = 1'b0;
        step(0, 1, 0, "R9 sticky");
        sts_wr = 1'b1; sts_wdata = 1'b1;
        step(0, 0, 0, "R11 clear");
        bus_grant = 1'b0; bus_err = 1'b1;
        step(0, 0, 0, "R9 error without grant");
        bus_err = 1'b0; wcfg(16'h0352);
        step(0, 0, 0, "R10 enable no flag");
        bus_grant = 1'b1; bus_err = 1'b1;
        step(0, 1, 1, "R10 enabled error");
        bus_err = 1'b0; sts_wr = 1'b1; sts_wdata = 1'b0;
        step(0, 1, 1, "R11 write zero");
        bus_err = 1'b1; sts_wr = 1'b1; sts_wdata = 1'b1;
        step(0, 1, 1, "R11 set wins");
        bus_err = 1'b0; sts_wr = 1'b1; sts_wdata = 1'b1;
        step(0, 0, 0, "R11 clear again");
        bus_err = 1'b1; wcfg(16'h0350);
        step(0, 1, 0, "R10 disabled error");
        bus_err = 1'b0; wcfg(16'h0352);
        step(0, 1, 1, "R10 enable raises irq");
        bus_grant = 1'b0;
        step(0, 1, 1, "R9 hold");
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule